// File: doc/BRIEF.md
# Multi-Mode Timer with PWM and Capture

This block is an up-counting timer for control tasks. A prescaler divides either the system clock or a synchronized external clock pin. Each prescaler expiry is one counter tick. The counter runs in one of three modes:

- **Free timer:** the counter simply runs.
- **Pulse-width modulation:** a second register sets the period and compare register 1 sets the high time.
- **Capture/compare:** the second register becomes a capture register fed by a second capture pin.

A dedicated capture register records the counter on rising edges of the first capture pin. Four sticky flags report captures and compare matches, and their OR drives an interrupt line. Software programs the block through a plain register write port and reads it back through a combinational read port. Software cannot load the counter; it can only clear it.

Top module: `mm_timer`

Register addresses:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Prescaler |
| 2 | Compare 1 |
| 3 | Period / compare 2 / capture 2 |
| 4 | Capture 1 (read only) |
| 5 | Counter (read only) |
| 6 | Flags |

Control word bits: [1:0] mode (0 timer, 1 PWM, 2 capture/compare, 3 behaves as timer), bit 2 external clock select, bit 3 clear strobe (reads as 0), bit 4 enable.

## Requirements
- R1: Outside PWM mode each tick adds one to the counter, which wraps from all ones to zero.
- R2: With prescaler value P (address 1, low PRE_W bits), a tick occurs on every (P+1)-th source event, counted from the last clear; with the system clock as source, the counter after k cycles equals floor(k/(P+1)).
- R3: Control bit 2 = 0 selects the system clock as the tick source. Bit 2 = 1 selects rising edges of the external clock pin, taken after a synchronizer. With enable (bit 4) at 0 the counter holds.
- R4: A control write with bit 3 set clears the counter and the prescaler at that clock edge. A write to address 5 does not change the counter.
- R5: In PWM mode (mode 1), when a tick finds the counter at period−1 (period = address 3), the counter returns to zero. A period of 0 means the full 2^CNT_W range.
- R6: In PWM mode the output is high while the count is below the high time H (address 2) and low otherwise. H = 0 keeps it low, and H ≥ period keeps it high. H=1 with period 2 gives a square wave at half the tick rate.
- R7: The output stays low in every mode other than PWM.
- R8: A rising edge on capture pin 1 copies the counter into address 4 and sets flag bit 0, in every mode. A falling edge does nothing.
- R9: In capture/compare mode (mode 2), a rising edge on capture pin 2 copies the counter into address 3 and sets flag bit 1. In other modes that pin changes neither address 3 nor the flag.
- R10: Flag bit 2 sets when a tick finds the counter at compare1−1. Flag bit 3 sets when a tick finds it at register2−1, outside capture/compare mode.
- R11: Writing 1 to a flag bit at address 6 clears it, and 0 bits are unaffected. A new set in the same cycle wins. The interrupt output is the OR of the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | AW | Read address |
| rdData | output | CNT_W | Read data (combinational) |
| extClk | input | 1 | External tick source pin |
| capPin1 | input | 1 | Capture pin for the dedicated capture register |
| capPin2 | input | 1 | Capture pin for the shared second register |
| tmrOut | output | 1 | PWM waveform output |
| irq | output | 1 | OR of all flags |

## Verification
The bench builds the timer with CNT_W = 8 and PRE_W = 4. The 8-bit counter makes the all-ones wrap reachable in a few hundred cycles. The 4-bit prescaler lets the bench sweep every divide value and compare each count against floor(k/(P+1)). The small width also allows a near-exhaustive PWM sweep over periods 1 to 9 and high times 0 to 10, which covers the zero-high-time and high-time-at-or-above-period corners. For each pair, both the output and the counter are compared every cycle with the arithmetic model.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_CAPT  = 2'd2,
    MODE_RSVD  = 2'd3
  } tmr_mode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;
    logic clr;
    logic cap1;
    logic cap2;
  } tmr_stb_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PRESC = 1;
  localparam int ADDR_CMP1  = 2;
  localparam int ADDR_REG2  = 3;
  localparam int ADDR_CAP1  = 4;
  localparam int ADDR_COUNT = 5;
  localparam int ADDR_FLAGS = 6;

  localparam int CTL_EXT = 2;
  localparam int CTL_CLR = 3;
  localparam int CTL_EN  = 4;

  localparam int NUM_FLAGS = 4;

endpackage

// File: rtl/mm_timer_ctrl.sv
module mm_timer_ctrl
  import mm_timer_pkg::*;
#(
  parameter int PRE_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic             capPin1,
  input  logic             capPin2,
  input  logic             extSel,
  input  logic             enable,
  input  logic [PRE_W-1:0] presc,
  input  logic             clrReq,
  output tmr_stb_t         stb
);

  localparam int NPINS = 3;
  localparam int SW    = SYNC_STAGES + 1;

  logic [NPINS-1:0]        pinVec;
  logic [NPINS-1:0][SW-1:0] syncQ;
  logic [NPINS-1:0]        riseVec;
  logic [PRE_W-1:0]        psc;
  logic                    srcEvt;
  logic                    pscDone;

  assign pinVec = {capPin2, capPin1, extClk};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        syncQ[i] <= {syncQ[i][SW-2:0], pinVec[i]};
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_edge
    assign riseVec[g] = syncQ[g][SW-2] & ~syncQ[g][SW-1];
  end

  assign srcEvt  = extSel ? riseVec[0] : 1'b1;
  assign pscDone = (psc == presc);

  always_ff @(posedge clk) begin
    if (!rstN || clrReq) begin
      psc <= '0;
    end else if (enable && srcEvt) begin
      psc <= pscDone ? '0 : psc + 1'b1;
    end
  end

  assign stb.tick = enable && srcEvt && pscDone;
  assign stb.clr  = clrReq;
  assign stb.cap1 = riseVec[1];
  assign stb.cap2 = riseVec[2];

endmodule

// File: rtl/mm_timer_dp.sv
module mm_timer_dp
  import mm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 15,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  tmr_stb_t         stb,
  output logic             clrReq,
  output logic             extSel,
  output logic             enable,
  output logic [PRE_W-1:0] presc,
  output logic             tmrOut,
  output logic             irq
);

  localparam logic [AW-1:0] A_CTRL  = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_PRESC = AW'(ADDR_PRESC);
  localparam logic [AW-1:0] A_CMP1  = AW'(ADDR_CMP1);
  localparam logic [AW-1:0] A_REG2  = AW'(ADDR_REG2);
  localparam logic [AW-1:0] A_CAP1  = AW'(ADDR_CAP1);
  localparam logic [AW-1:0] A_COUNT = AW'(ADDR_COUNT);
  localparam logic [AW-1:0] A_FLAGS = AW'(ADDR_FLAGS);

  tmr_mode_e              modeReg;
  logic [CNT_W-1:0]       count, cmp1Reg, reg2Reg, cap1Reg;
  logic [CNT_W-1:0]       cmp1Last, reg2Last;
  logic [NUM_FLAGS-1:0]   flags, setVec, clrMask;
  logic                   pwmMode, capMode, wrCtrl, wrReg2, atPeriod, outNext;

  assign wrCtrl   = wrEn && (wrAddr == A_CTRL);
  assign wrReg2   = wrEn && (wrAddr == A_REG2);
  assign clrReq   = wrCtrl && wrData[CTL_CLR];
  assign pwmMode  = (modeReg == MODE_PWM);
  assign capMode  = (modeReg == MODE_CAPT);
  assign cmp1Last = cmp1Reg - 1'b1;
  assign reg2Last = reg2Reg - 1'b1;
  assign atPeriod = pwmMode && (count == reg2Last);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_TIMER;
      extSel  <= 1'b0;
      enable  <= 1'b0;
      presc   <= '0;
      cmp1Reg <= '0;
    end else begin
      if (wrCtrl) begin
        modeReg <= tmr_mode_e'(wrData[1:0]);
        extSel  <= wrData[CTL_EXT];
        enable  <= wrData[CTL_EN];
      end
      if (wrEn && wrAddr == A_PRESC) presc   <= wrData[PRE_W-1:0];
      if (wrEn && wrAddr == A_CMP1)  cmp1Reg <= wrData;
    end
  end

  // counter: clear has priority, PWM period wraps early
  always_ff @(posedge clk) begin
    if (!rstN || stb.clr) begin
      count <= '0;
    end else if (stb.tick) begin
      count <= atPeriod ? '0 : count + 1'b1;
    end
  end

  // capture registers; a capture beats a software write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cap1Reg <= '0;
      reg2Reg <= '0;
    end else begin
      if (stb.cap1) cap1Reg <= count;
      if (capMode && stb.cap2) reg2Reg <= count;
      else if (wrReg2)         reg2Reg <= wrData;
    end
  end

  // PWM waveform
  always_comb begin
    outNext = tmrOut;
    if (!pwmMode) begin
      outNext = 1'b0;
    end else if (stb.clr || (stb.tick && atPeriod)) begin
      outNext = (cmp1Reg != '0);
    end else if (stb.tick && count == cmp1Last) begin
      outNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tmrOut <= 1'b0;
    else       tmrOut <= outNext;
  end

  // sticky flags
  assign setVec[0] = stb.cap1;
  assign setVec[1] = stb.cap2 && capMode;
  assign setVec[2] = stb.tick && !stb.clr && (count == cmp1Last);
  assign setVec[3] = stb.tick && !stb.clr && !capMode && (count == reg2Last);
  assign clrMask   = (wrEn && wrAddr == A_FLAGS) ? wrData[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | setVec;
  end

  assign irq = |flags;

  always_comb begin
    case (rdAddr)
      A_CTRL:  rdData = CNT_W'({enable, 1'b0, extSel, modeReg});
      A_PRESC: rdData = CNT_W'(presc);
      A_CMP1:  rdData = cmp1Reg;
      A_REG2:  rdData = reg2Reg;
      A_CAP1:  rdData = cap1Reg;
      A_COUNT: rdData = count;
      A_FLAGS: rdData = CNT_W'(flags);
      default: rdData = '0;
    endcase
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> count == '0); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick && !stb.clr && !atPeriod |=> count == CNT_W'($past(count) + 1'b1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick && !stb.clr |=> $stable(count)); // R3
  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick && !stb.clr && atPeriod |=> count == '0); // R5
  AST_CAP1_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.cap1 |=> cap1Reg == $past(count) && flags[0]); // R8
  AST_CAP2_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    stb.cap2 && !capMode && !wrReg2 |=> $stable(reg2Reg)); // R9
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pwmMode && !wrCtrl |=> !tmrOut); // R7

endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 15,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             extClk,
  input  logic             capPin1,
  input  logic             capPin2,
  output logic             tmrOut,
  output logic             irq
);

  tmr_stb_t         stb;
  logic             clrReq, extSel, enable;
  logic [PRE_W-1:0] presc;

  mm_timer_ctrl #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .extClk(extClk), .capPin1(capPin1),
    .capPin2(capPin2), .extSel(extSel), .enable(enable), .presc(presc),
    .clrReq(clrReq), .stb(stb)
  );

  mm_timer_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .stb(stb), .clrReq(clrReq),
    .extSel(extSel), .enable(enable), .presc(presc), .tmrOut(tmrOut), .irq(irq)
  );

endmodule

// File: tb/mm_timer_tb.sv
`timescale 1ns/1ps
module mm_timer_tb;

  localparam int CNT_W = 8;
  localparam int PRE_W = 4;
  localparam int AW    = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [AW-1:0]    wrAddr;
  logic [CNT_W-1:0] wrData;
  logic [AW-1:0]    rdAddr;
  logic [CNT_W-1:0] rdData;
  logic             extClk, capPin1, capPin2, tmrOut, irq;

  int checks = 0;
  int errors = 0;
  logic [CNT_W-1:0] capVal, capVal2, tmp;

  always #5 clk = ~clk;

  mm_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extClk(extClk), .capPin1(capPin1),
    .capPin2(capPin2), .tmrOut(tmrOut), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] cw(input int mode, input bit ext,
                                          input bit clr, input bit en);
    return CNT_W'(mode | (int'(ext) << 2) | (int'(clr) << 3) | (int'(en) << 4));
  endfunction

  task automatic wr(input int a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input int a, output logic [CNT_W-1:0] v);
    rdAddr = AW'(a); #0.1;
    v = rdData;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    extClk = 1'b0; capPin1 = 1'b0; capPin2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    step(1);

    // reset state
    rd(5, tmp); chk("R1 reset count", tmp, 0);
    rd(0, tmp); chk("R3 reset ctrl", tmp, 0);
    chk("R7 reset out", tmrOut, 0);
    chk("R11 reset irq", irq, 0);

    // R2 prescaler sweep on system clock
    for (int p = 0; p < (1 << PRE_W); p++) begin
      wr(1, CNT_W'(p));
      wr(0, cw(0, 0, 0, 1));
      wr(0, cw(0, 0, 1, 1));
      for (int k = 1; k <= 3 * (p + 1) + 1; k++) begin
        step(1);
        rd(5, tmp); chk("R2 prescaled count", tmp, k / (p + 1));
      end
    end
    wr(1, '0);

    // R1 R10 R7 timer mode, matches and wrap
    wr(0, cw(0, 0, 0, 1));
    wr(2, 8'd10);
    wr(3, 8'd20);
    wr(0, cw(0, 0, 1, 1));
    wr(6, 8'h0F);
    step(8);
    rd(6, tmp); chk("R10 no match before compare", tmp, 0);
    step(1);
    rd(5, tmp); chk("R1 count step", tmp, 10);
    rd(6, tmp); chk("R10 compare1 flag", tmp, 4);
    chk("R11 irq on flag", irq, 1);
    step(10);
    rd(6, tmp); chk("R10 compare2 flag", tmp, 12);
    chk("R7 out low in timer", tmrOut, 0);
    step(236);
    rd(5, tmp); chk("R1 wrap to zero", tmp, 0);
    chk("R7 out low after wrap", tmrOut, 0);

    // R3 R4 freeze and no direct load
    wr(0, cw(0, 0, 0, 0));
    rd(5, capVal);
    step(5);
    rd(5, tmp); chk("R3 disabled holds", tmp, capVal);
    wr(5, 8'h77);
    step(1);
    rd(5, tmp); chk("R4 direct write ignored", tmp, capVal);
    wr(0, cw(0, 0, 1, 0));
    rd(5, tmp); chk("R4 clear", tmp, 0);

    // R3 external clock source: five rising edges
    wr(0, cw(0, 1, 1, 1));
    for (int e = 0; e < 5; e++) begin
      @(negedge clk); extClk = 1'b1; step(3);
      @(negedge clk); extClk = 1'b0; step(3);
    end
    step(4);
    rd(5, tmp); chk("R3 external edges counted", tmp, 5);

    // R8 capture 1
    wr(0, cw(0, 0, 1, 1));
    wr(6, 8'h0F);
    step(6);
    wr(0, cw(0, 0, 0, 0));
    rd(5, capVal);
    @(negedge clk); capPin1 = 1'b1; step(5);
    rd(4, tmp); chk("R8 capture1 value", tmp, capVal);
    rd(6, tmp); chk("R8 capture1 flag", tmp & 1, 1);
    wr(0, cw(0, 0, 0, 1));
    step(4);
    wr(0, cw(0, 0, 0, 0));
    rd(5, capVal2);
    chk("R8 counter moved", int'(capVal2 != capVal), 1);
    @(negedge clk); capPin1 = 1'b0; step(5);
    rd(4, tmp); chk("R8 falling edge ignored", tmp, capVal);

    // R9 capture 2 ignored outside capture mode
    wr(3, 8'h33);
    @(negedge clk); capPin2 = 1'b1; step(5);
    @(negedge clk); capPin2 = 1'b0; step(5);
    rd(3, tmp); chk("R9 reg2 kept in timer mode", tmp, 8'h33);
    rd(6, tmp); chk("R9 no flag in timer mode", (tmp >> 1) & 1, 0);

    // R9 capture 2 in capture mode
    wr(0, cw(2, 0, 0, 0));
    @(negedge clk); capPin2 = 1'b1; step(5);
    rd(3, tmp); chk("R9 capture2 value", tmp, capVal2);
    rd(6, tmp); chk("R9 capture2 flag", tmp & 3, 3);
    @(negedge clk); capPin2 = 1'b0; step(4);

    // R11 write-one-to-clear
    wr(6, 8'h01);
    rd(6, tmp); chk("R11 clear bit0 only", tmp & 3, 2);
    chk("R11 irq still set", irq, 1);
    wr(6, 8'h0F);
    rd(6, tmp); chk("R11 all cleared", tmp, 0);
    chk("R11 irq clear", irq, 0);

    // R5 R6 PWM sweep
    for (int per = 1; per <= 9; per++) begin
      for (int hi = 0; hi <= 10; hi++) begin
        wr(0, cw(1, 0, 0, 1));
        wr(2, CNT_W'(hi));
        wr(3, CNT_W'(per));
        wr(0, cw(1, 0, 1, 1));
        chk("R6 out after clear", tmrOut, int'(0 < hi));
        for (int k = 1; k <= 2 * per + 2; k++) begin
          step(1);
          rd(5, tmp); chk("R5 pwm count", tmp, k % per);
          chk("R6 pwm out", tmrOut, int'((k % per) < hi));
        end
      end
    end

    // R5 period zero uses full range
    wr(2, 8'd3);
    wr(3, 8'd0);
    wr(0, cw(1, 0, 1, 1));
    step(255);
    rd(5, tmp); chk("R5 period zero count", tmp, 255);
    chk("R6 low late in period", tmrOut, 0);
    step(1);
    rd(5, tmp); chk("R5 period zero wrap", tmp, 0);
    chk("R6 high at wrap", tmrOut, 1);

    // R7 leaving PWM drops output
    wr(0, cw(0, 0, 0, 1));
    step(1);
    chk("R7 out low after leaving pwm", tmrOut, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule